// File: doc/BRIEF.md
# Configuration Register Bank with Station-Address Shadow Store

This block holds a handful of 32-bit configuration words reachable over a plain register port. It also keeps a small byte store that carries the station address. Two of the words are fixed activity constants that never change. The third holds five live control bits: a loopback pass-through enable, a write enable for the address store, a sleep-flavour select, a media auto-select and one spare bit.

The address store is filled at start-up by an EEPROM controller through a loader port. The same port can also load the control word. Afterwards, software reaches the store through a separate byte-wide address-PROM port. Writes on that port land only while the store write enable is set.

Two reset domains apply. The asynchronous hard reset clears everything. The soft reset and the stop command leave all stored state in place and only cancel a read response that is in flight.

Top module: `cfg_regbank`

## Requirements
- R1: Register index 0 and register index 1 read 16'h0005 in bits 15:0 from hard reset on, and bus writes to them never change that value.
- R2: Bits 31:16 of every register read are zero, and register index 3 reads all zeros.
- R3: Register index 2 stores only bit 14 (loopback pass), bit 8 (store write enable), bit 7 (spare), bit 2 (sleep flavour) and bit 1 (auto-select). All other bits read zero. Bits 14, 2 and 1 drive `loop_pass_en`, `sleep_sel` and `auto_sel`.
- R4: Hard reset clears register index 2 and every byte of the address store to zero.
- R5: A pulse on `soft_rst` or on `stop_req` leaves register index 2 and the address store unchanged.
- R6: A read on the address-PROM port returns the addressed store byte one cycle later, with `prom_rvalid` high for that cycle.
- R7: A write on the address-PROM port updates the store only while bit 8 of register index 2 is one. Otherwise it is dropped.
- R8: A loader byte write always updates the store, whatever bit 8 holds. A loader configuration write replaces register index 2 with the bits of R3.
- R9: When a loader configuration write and a bus write to register index 2 fall in the same cycle, the loader value is kept.
- R10: A register read returns data one cycle after `reg_rd`, with `reg_rvalid` high only in that cycle.
- R11: A read request issued in a cycle in which `soft_rst` or `stop_req` is high produces no valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Soft reset pulse |
| stop_req | input | 1 | Stop command pulse |
| reg_sel | input | 2 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Register read data valid |
| prom_addr | input | 4 | Address-PROM byte address |
| prom_wr | input | 1 | Address-PROM write strobe |
| prom_rd | input | 1 | Address-PROM read strobe |
| prom_wdata | input | 8 | Address-PROM write byte |
| prom_rdata | output | 8 | Address-PROM read byte |
| prom_rvalid | output | 1 | Address-PROM read valid |
| ld_byte_we | input | 1 | Loader byte write strobe |
| ld_byte_addr | input | 4 | Loader byte address |
| ld_byte_data | input | 8 | Loader byte data |
| ld_cfg_we | input | 1 | Loader configuration write strobe |
| ld_cfg_data | input | 16 | Loader configuration word |
| loop_pass_en | output | 1 | Loopback pass-through enable |
| sleep_sel | output | 1 | Sleep flavour select |
| auto_sel | output | 1 | Media auto-select |

## Verification
The hardest situation to reach is a collision between the loader and the bus on the control word in one cycle. Close behind it is a soft reset that lands on the same edge as a read request. The bench drives both strobes in the same low clock phase so that they meet at a single edge. It then reads back the control word and the strobe to see which source won and whether the response was dropped. A second hard reset late in the run shows that a store byte written earlier through the loader really returns to zero.

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int          SHADOW_BYTES = 16,
  parameter logic [15:0] ACT_VALUE    = 16'h0005,
  localparam int         AW           = $clog2(SHADOW_BYTES)
) (
  input  logic          clk,
  input  logic          hrst_n,
  input  logic          soft_rst,
  input  logic          stop_req,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_rvalid,
  input  logic [AW-1:0] prom_addr,
  input  logic          prom_wr,
  input  logic          prom_rd,
  input  logic [7:0]    prom_wdata,
  output logic [7:0]    prom_rdata,
  output logic          prom_rvalid,
  input  logic          ld_byte_we,
  input  logic [AW-1:0] ld_byte_addr,
  input  logic [7:0]    ld_byte_data,
  input  logic          ld_cfg_we,
  input  logic [15:0]   ld_cfg_data,
  output logic          loop_pass_en,
  output logic          sleep_sel,
  output logic          auto_sel
);

  localparam int B_LOOP  = 14;
  localparam int B_SHWE  = 8;
  localparam int B_SPARE = 7;
  localparam int B_SLEEP = 2;
  localparam int B_AUTO  = 1;
  localparam logic [15:0] CFG_MASK =
    16'((1 << B_LOOP) | (1 << B_SHWE) | (1 << B_SPARE) | (1 << B_SLEEP) | (1 << B_AUTO));
  localparam logic [1:0] SEL_CFG = 2'd2;

  logic [15:0] cfg_q;
  logic [7:0]  shadow_q [SHADOW_BYTES];
  logic [15:0] rdata_q;
  logic        rvalid_q;
  logic [7:0]  prdata_q;
  logic        prvalid_q;
  logic [15:0] reg_mux;
  logic        quiet;
  logic        unused_bits;

  assign quiet       = soft_rst | stop_req;
  assign unused_bits = ^reg_wdata[31:16];

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      cfg_q <= '0;
    end else if (ld_cfg_we) begin
      cfg_q <= ld_cfg_data & CFG_MASK;
    end else if (reg_wr && reg_sel == SEL_CFG) begin
      cfg_q <= reg_wdata[15:0] & CFG_MASK;
    end
  end

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      for (int i = 0; i < SHADOW_BYTES; i++) shadow_q[i] <= '0;
    end else begin
      if (prom_wr && cfg_q[B_SHWE]) shadow_q[prom_addr] <= prom_wdata;
      if (ld_byte_we) shadow_q[ld_byte_addr] <= ld_byte_data;
    end
  end

  assign reg_mux = (reg_sel < 2'd2) ? ACT_VALUE :
                   (reg_sel == SEL_CFG) ? cfg_q : 16'h0000;

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
      prdata_q  <= '0;
      prvalid_q <= 1'b0;
    end else begin
      rvalid_q  <= reg_rd & ~quiet;
      prvalid_q <= prom_rd & ~quiet;
      if (reg_rd) rdata_q <= reg_mux;
      if (prom_rd) prdata_q <= shadow_q[prom_addr];
    end
  end

  assign reg_rdata    = {16'h0000, rdata_q};
  assign reg_rvalid   = rvalid_q;
  assign prom_rdata   = prdata_q;
  assign prom_rvalid  = prvalid_q;
  assign loop_pass_en = cfg_q[B_LOOP];
  assign sleep_sel    = cfg_q[B_SLEEP];
  assign auto_sel     = cfg_q[B_AUTO];

  // R1
  fixed_value_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    reg_rd && reg_sel < 2'd2 |=> reg_rdata[15:0] == ACT_VALUE);

  // R7
  prom_wr_drop_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    prom_wr && !cfg_q[B_SHWE] && !ld_byte_we
    |=> shadow_q[$past(prom_addr)] == $past(shadow_q[prom_addr]));

  // R9
  loader_wins_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    ld_cfg_we |=> cfg_q == $past(ld_cfg_data & CFG_MASK));

  // R5
  soft_keep_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    quiet && !ld_cfg_we && !(reg_wr && reg_sel == SEL_CFG) |=> $stable(cfg_q));

  // R11
  quiet_drop_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    quiet |=> !reg_rvalid && !prom_rvalid);

  // R6
  prom_valid_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    prom_rd && !quiet |=> prom_rvalid);

endmodule

// File: tb/cfg_regbank_tb.sv
module cfg_regbank_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic hrst_n = 1'b0, soft_rst = 1'b0, stop_req = 1'b0;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_rvalid;
  logic [3:0] prom_addr = '0;
  logic prom_wr = 1'b0, prom_rd = 1'b0;
  logic [7:0] prom_wdata = '0, prom_rdata;
  logic prom_rvalid;
  logic ld_byte_we = 1'b0, ld_cfg_we = 1'b0;
  logic [3:0] ld_byte_addr = '0;
  logic [7:0] ld_byte_data = '0;
  logic [15:0] ld_cfg_data = '0;
  logic loop_pass_en, sleep_sel, auto_sel;

  int checks = 0, failures = 0;

  cfg_regbank dut_i (
    .clk(clk), .hrst_n(hrst_n), .soft_rst(soft_rst), .stop_req(stop_req),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .prom_addr(prom_addr), .prom_wr(prom_wr), .prom_rd(prom_rd),
    .prom_wdata(prom_wdata), .prom_rdata(prom_rdata), .prom_rvalid(prom_rvalid),
    .ld_byte_we(ld_byte_we), .ld_byte_addr(ld_byte_addr), .ld_byte_data(ld_byte_data),
    .ld_cfg_we(ld_cfg_we), .ld_cfg_data(ld_cfg_data),
    .loop_pass_en(loop_pass_en), .sleep_sel(sleep_sel), .auto_sel(auto_sel));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [31:0] d, output logic v);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata; v = reg_rvalid;
  endtask

  task automatic wr_prom(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); prom_addr = a; prom_wdata = d; prom_wr = 1'b1;
    @(negedge clk); prom_wr = 1'b0;
  endtask

  task automatic rd_prom(input logic [3:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); prom_addr = a; prom_rd = 1'b1;
    @(negedge clk); prom_rd = 1'b0; d = prom_rdata; v = prom_rvalid;
  endtask

  // {sel, write data, expected read}
  localparam logic [65:0] VEC [8] = '{
    {2'd0, 32'hFFFF_FFFF, 32'h0000_0005},
    {2'd1, 32'h0000_0000, 32'h0000_0005},
    {2'd2, 32'hFFFF_FFFF, 32'h0000_4186},
    {2'd2, 32'h0000_0004, 32'h0000_0004},
    {2'd2, 32'h1234_0102, 32'h0000_0102},
    {2'd3, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'd2, 32'h0000_4080, 32'h0000_4080},
    {2'd2, 32'h0000_0000, 32'h0000_0000}};

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [7:0] b;
    logic v;
    repeat (3) @(negedge clk);
    hrst_n = 1'b1;

    // R1 R2 R4 reset state
    rd_reg(2'd0, d, v); check("R1 reg0 reset", d, 32'h5); check("R10 valid", {31'b0, v}, 1);
    rd_reg(2'd1, d, v); check("R1 reg1 reset", d, 32'h5);
    rd_reg(2'd2, d, v); check("R4 cfg reset", d, 32'h0);
    for (int i = 0; i < 16; i++) begin
      rd_prom(4'(i), b, v); check("R4 shadow reset", {24'b0, b}, 0);
    end
    @(negedge clk); check("R10 idle no valid", {31'b0, reg_rvalid}, 0);

    // R1 R2 R3 vector walk
    for (int k = 0; k < 8; k++) begin
      wr_reg(VEC[k][65:64], VEC[k][63:32]);
      rd_reg(VEC[k][65:64], d, v);
      check("R1/R2/R3 vector", d, VEC[k][31:0]);
    end
    wr_reg(2'd2, 32'h0000_4006);
    check("R3 outputs", {29'b0, loop_pass_en, sleep_sel, auto_sel}, 32'b111);
    wr_reg(2'd2, 32'h0000_0000);
    check("R3 outputs clear", {29'b0, loop_pass_en, sleep_sel, auto_sel}, 32'b000);

    // R7 write gated by bit 8
    wr_prom(4'd3, 8'hAA);
    rd_prom(4'd3, b, v); check("R7 dropped", {24'b0, b}, 0); check("R6 valid", {31'b0, v}, 1);
    wr_reg(2'd2, 32'h0000_0100);
    wr_prom(4'd3, 8'hAA);
    rd_prom(4'd3, b, v); check("R7 accepted", {24'b0, b}, 32'hAA);

    // R8 loader paths
    wr_reg(2'd2, 32'h0);
    @(negedge clk); ld_byte_we = 1'b1; ld_byte_addr = 4'd5; ld_byte_data = 8'h5C;
    @(negedge clk); ld_byte_we = 1'b0;
    rd_prom(4'd5, b, v); check("R8 loader byte", {24'b0, b}, 32'h5C);
    @(negedge clk); ld_cfg_we = 1'b1; ld_cfg_data = 16'hFFFF;
    @(negedge clk); ld_cfg_we = 1'b0;
    rd_reg(2'd2, d, v); check("R8 loader cfg", d, 32'h4186);

    // R9 collision
    @(negedge clk); ld_cfg_we = 1'b1; ld_cfg_data = 16'h0006;
    reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h0000_4000;
    @(negedge clk); ld_cfg_we = 1'b0; reg_wr = 1'b0;
    rd_reg(2'd2, d, v); check("R9 loader wins", d, 32'h6);

    // R5 soft reset and stop keep state
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0; stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    rd_reg(2'd2, d, v); check("R5 cfg kept", d, 32'h6);
    rd_prom(4'd5, b, v); check("R5 shadow kept", {24'b0, b}, 32'h5C);

    // R11 read during soft reset
    @(negedge clk); reg_sel = 2'd0; reg_rd = 1'b1; prom_rd = 1'b1; soft_rst = 1'b1;
    @(negedge clk); reg_rd = 1'b0; prom_rd = 1'b0; soft_rst = 1'b0;
    check("R11 no reg valid", {31'b0, reg_rvalid}, 0);
    check("R11 no prom valid", {31'b0, prom_rvalid}, 0);

    // R4 second hard reset
    @(negedge clk); hrst_n = 1'b0;
    @(negedge clk); hrst_n = 1'b1;
    rd_reg(2'd2, d, v); check("R4 cfg cleared", d, 32'h0);
    rd_prom(4'd5, b, v); check("R4 shadow cleared", {24'b0, b}, 0);
    rd_prom(4'd3, b, v); check("R4 shadow cleared 3", {24'b0, b}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule